// File: doc/BRIEF.md
# Video RAM Contention Wait Generator

This block arbitrates a single video RAM shared by a CPU and the raster fetch logic. It decodes each CPU request against a configurable screen address window. When the anti-streak control is on and the raster is drawing visible pixels, a screen access holds the CPU on its WAIT input until the raster enters a blanking period. The access then gets the RAM for one clock. While the CPU owns the RAM, the video fetch output enable is turned off, and a write drives the RAM write strobe for that single clock.

When the control is off, screen accesses are granted at once and the display may tear. Accesses outside the window are ignored. An access first seen in the final clock of a blanking run is held back to the next blanking run, so the first visible fetch is never disturbed. A saturating counter reports how many clocks the most recent WAIT lasted.

Top module: `vram_wait_gen`

## Requirements
- R1: In reset and on the first cycle after it, cpu_wait=0, cpu_grant=0, ram_we=0, vid_oe=1 and stall_count=0.
- R2: With arb_en=1, a request whose address lies in [SCR_BASE, SCR_BASE+SCR_SIZE), sampled while hblank=0 and vblank=0, raises cpu_wait from the next clock edge.
- R3: cpu_wait stays high while cpu_req is held, through a visible segment of any length (64 clocks or more included). It falls at the first edge that samples blanking (hblank or vblank high) with blank_last=0, and cpu_grant is high in the following cycle.
- R4: With arb_en=1, a screen request sampled during blanking with blank_last=0 is granted at the next edge and never raises cpu_wait.
- R5: A request outside the screen window never raises cpu_wait or cpu_grant.
- R6: With arb_en=0, a screen request is granted at the next edge whatever the blanking state, with no wait.
- R7: cpu_grant lasts exactly one cycle. During it vid_oe=0, and ram_we equals the cpu_wr sampled with the request. At all other times ram_we=0 and vid_oe=1.
- R8: A screen request first sampled with blank_last=1 waits for the next blanking run, as in R3.
- R9: stall_count equals the number of cycles the most recent cpu_wait pulse was high, saturating at 2^CNT_W-1. It holds until the next pulse begins.
- R10: After a grant, no further grant is issued until cpu_req has been low for at least one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_req | input | 1 | CPU memory request, held until granted |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| hblank | input | 1 | Horizontal blanking flag |
| vblank | input | 1 | Vertical blanking flag |
| blank_last | input | 1 | High in the final clock of a blanking run |
| arb_en | input | 1 | Anti-streak arbitration enable |
| cpu_wait | output | 1 | WAIT to the CPU |
| cpu_grant | output | 1 | CPU owns the RAM this cycle |
| ram_we | output | 1 | RAM write strobe |
| vid_oe | output | 1 | Video fetch output enable |
| stall_count | output | CNT_W | Length of the most recent WAIT, in clocks |

## Verification
The bench builds the block with a 1 KiB screen window at 0x3C00 and CNT_W=6. It drives a raster of 80 visible clocks and 16 blanking clocks per line, over 4 visible lines and 2 blanking lines. With this raster, stalls across most of a line exceed 64 clocks and drive the counter into saturation, while a stall started near the line end gives an exact short count. Accesses are placed at both edges of the window, inside vertical blanking, on the last blanking tick and with arbitration off.

// File: rtl/vwg_pkg.sv
package vwg_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_STALL   = 2'd1,
        ARB_GRANT   = 2'd2,
        ARB_RELEASE = 2'd3
    } arb_state_e;

    typedef struct packed {
        logic valid;   // request present
        logic hit;     // request inside the screen window
        logic wr;      // request is a write
    } cpu_acc_t;

    function automatic logic in_window(input logic [31:0] a,
                                       input logic [31:0] base,
                                       input logic [31:0] size);
        return (a >= base) && ((a - base) < size);
    endfunction

endpackage

// File: rtl/vwg_decode.sv
module vwg_decode
    import vwg_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int SCR_BASE = 'h3C00,
    parameter int SCR_SIZE = 1024
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    output cpu_acc_t          acc
);
    localparam logic [31:0] BASE_W = 32'(SCR_BASE);
    localparam logic [31:0] SIZE_W = 32'(SCR_SIZE);

    always_comb begin
        acc.valid = cpu_req;
        acc.wr    = cpu_wr;
        acc.hit   = cpu_req && in_window(32'(cpu_addr), BASE_W, SIZE_W);
    end
endmodule

// File: rtl/vwg_arbiter.sv
module vwg_arbiter
    import vwg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cpu_acc_t acc,
    input  logic     arb_en,
    input  logic     hblank,
    input  logic     vblank,
    input  logic     blank_last,
    output logic     cpu_wait,
    output logic     cpu_grant,
    output logic     ram_we,
    output logic     vid_oe
);
    arb_state_e state_q, state_d;
    logic       wr_q;
    logic       blank_ok;

    assign blank_ok = (hblank || vblank) && !blank_last;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:
                if (acc.hit)
                    state_d = (!arb_en || blank_ok) ? ARB_GRANT : ARB_STALL;
            ARB_STALL:
                if (!acc.valid)                state_d = ARB_IDLE;
                else if (blank_ok || !arb_en)  state_d = ARB_GRANT;
            ARB_GRANT:
                state_d = ARB_RELEASE;
            ARB_RELEASE:
                if (!acc.valid) state_d = ARB_IDLE;
            default:
                state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ARB_IDLE && acc.hit)
                wr_q <= acc.wr;
        end
    end

    assign cpu_wait  = (state_q == ARB_STALL);
    assign cpu_grant = (state_q == ARB_GRANT);
    assign ram_we    = cpu_grant && wr_q;
    assign vid_oe    = !cpu_grant;

    // R2: a wait only ever starts from an enabled screen hit
    p_wait_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_wait) |-> $past(acc.hit && arb_en));

    // R3 / R8: wait released with a held request only by a usable blanking tick
    p_release_blank_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(cpu_wait) && $past(acc.valid) && $past(arb_en))
            |-> (cpu_grant && $past(blank_ok)));

    // R4: every grant comes from a request that was present
    p_grant_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_grant) |-> $past(acc.valid));

    // R10: grant never repeats back to back
    p_single_grant_r10: assert property (@(posedge clk) disable iff (rst)
        cpu_grant |=> !cpu_grant);

    // R7: after a grant the video side owns the RAM again with no write
    p_return_video_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_grant |=> (vid_oe && !ram_we));
endmodule

// File: rtl/vwg_stall_ctr.sv
module vwg_stall_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic stall_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            count      <= '0;
            stall_prev <= 1'b0;
        end else begin
            stall_prev <= stall;
            if (stall) begin
                if (!stall_prev)          count <= CNT_W'(1);
                else if (count != CNT_MAX) count <= count + 1'b1;
            end
        end
    end

    // R9: a finished wait always leaves a non-zero length
    p_count_set_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> (count != '0));

    // R9: between waits the reported length is frozen
    p_count_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!stall && $past(!stall)) |-> $stable(count));
endmodule

// File: rtl/vram_wait_gen.sv
module vram_wait_gen
    import vwg_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int SCR_BASE = 'h3C00,
    parameter int SCR_SIZE = 1024,
    parameter int CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic              hblank,
    input  logic              vblank,
    input  logic              blank_last,
    input  logic              arb_en,
    output logic              cpu_wait,
    output logic              cpu_grant,
    output logic              ram_we,
    output logic              vid_oe,
    output logic [CNT_W-1:0]  stall_count
);
    cpu_acc_t acc;

    vwg_decode #(
        .ADDR_W  (ADDR_W),
        .SCR_BASE(SCR_BASE),
        .SCR_SIZE(SCR_SIZE)
    ) u_decode (
        .cpu_addr(cpu_addr),
        .cpu_req (cpu_req),
        .cpu_wr  (cpu_wr),
        .acc     (acc)
    );

    vwg_arbiter u_arbiter (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .arb_en    (arb_en),
        .hblank    (hblank),
        .vblank    (vblank),
        .blank_last(blank_last),
        .cpu_wait  (cpu_wait),
        .cpu_grant (cpu_grant),
        .ram_we    (ram_we),
        .vid_oe    (vid_oe)
    );

    vwg_stall_ctr #(.CNT_W(CNT_W)) u_stall_ctr (
        .clk  (clk),
        .rst  (rst),
        .stall(cpu_wait),
        .count(stall_count)
    );

    // R5: wait and grant are never both high
    p_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wait && cpu_grant));
endmodule

// File: tb/vram_wait_gen_bench.sv
module vram_wait_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int SCR_BASE = 'h3C00;
    localparam int SCR_SIZE = 1024;
    localparam int CNT_W = 6;
    localparam int H_VIS = 80, H_TOT = 96, V_VIS = 4, V_TOT = 6;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    typedef struct {
        int addr; bit wr; int sh; int sl; bit en; int hold; bit off;
        int exp_wait; int exp_cnt;
    } op_t;

    logic clk = 0, rst = 1;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic cpu_req = 0, cpu_wr = 0, hblank = 0, vblank = 0, blank_last = 0, arb_en = 1;
    logic cpu_wait, cpu_grant, ram_we, vid_oe;
    logic [CNT_W-1:0] stall_count;

    int compared = 0, mismatched = 0;

    vram_wait_gen #(.ADDR_W(ADDR_W), .SCR_BASE(SCR_BASE), .SCR_SIZE(SCR_SIZE), .CNT_W(CNT_W))
    u_vram_wait_gen (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
        .hblank(hblank), .vblank(vblank), .blank_last(blank_last), .arb_en(arb_en),
        .cpu_wait(cpu_wait), .cpu_grant(cpu_grant), .ram_we(ram_we), .vid_oe(vid_oe),
        .stall_count(stall_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: phase 0 free, 1 stalled, 2 owning, 3 waiting for request drop
    int m_phase = 0, m_cnt = 0, m_wr = 0, m_prev_stall = 0;
    always @(posedge clk) begin
        int hit, ok;
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_wr = 0; m_prev_stall = 0;
        end else begin
            hit = cpu_req && (cpu_addr >= SCR_BASE) && (cpu_addr < SCR_BASE + SCR_SIZE);
            ok  = (hblank || vblank) && !blank_last;
            if (m_phase == 1) begin
                m_cnt = m_prev_stall ? ((m_cnt < CNT_MAX) ? m_cnt + 1 : m_cnt) : 1;
            end
            m_prev_stall = (m_phase == 1);
            case (m_phase)
                0: if (hit) begin m_wr = cpu_wr; m_phase = (!arb_en || ok) ? 2 : 1; end
                1: if (!cpu_req) m_phase = 0; else if (ok || !arb_en) m_phase = 2;
                2: m_phase = 3;
                default: if (!cpu_req) m_phase = 0;
            endcase
        end
    end

    // raster and CPU agent, all driven at the falling edge
    int hc = 0, lc = 0, started = 0, cycles = 0;
    op_t q[$];
    op_t cur;
    bit busy = 0, granted = 0, saw_wait = 0;
    int gap = 0, tick = 0, done = 0, grants = 0, run = 0, max_run = 0;

    always @(negedge clk) begin
        cycles++;
        if (started) begin
            chk("R2/R3/R8 wait", cpu_wait, m_phase == 1);
            chk("R4/R6 grant", cpu_grant, m_phase == 2);
            chk("R7 ram_we", ram_we, (m_phase == 2) && m_wr);
            chk("R7 vid_oe", vid_oe, m_phase != 2);
            chk("R9 stall_count", stall_count, m_cnt);
        end
        if (cpu_grant) grants++;
        run = cpu_wait ? run + 1 : 0;
        if (run > max_run) max_run = run;
        if (busy && cpu_wait) saw_wait = 1;
        if (busy && cpu_grant) granted = 1;

        hc = (hc + 1) % H_TOT;
        if (hc == 0) lc = (lc + 1) % V_TOT;
        hblank = (hc >= H_VIS);
        vblank = (lc >= V_VIS);
        blank_last = (hc == H_TOT - 1) && (((lc + 1) % V_TOT) < V_VIS);

        if (!rst) begin
            if (busy) begin
                if (cur.off) begin
                    chk("R5 offscreen quiet", cpu_wait || cpu_grant, 0);
                    tick++;
                    if (tick >= 4) begin cpu_req = 0; busy = 0; done++; gap = 3; end
                end else if (granted) begin
                    if (cur.hold == 0) begin
                        cpu_req = 0; busy = 0; done++; gap = 3;
                        if (cur.exp_wait >= 0) chk("R2/R4/R6/R8 wait seen", saw_wait, cur.exp_wait);
                        if (cur.exp_cnt >= 0) chk("R9 count after op", stall_count, cur.exp_cnt);
                    end else cur.hold--;
                end
            end else if (gap > 0) begin
                gap--;
            end else if (q.size() > 0) begin
                if ((q[0].sh < 0 || q[0].sh == hc) && (q[0].sl < 0 || q[0].sl == lc)) begin
                    cur = q.pop_front();
                    arb_en = cur.en; cpu_addr = ADDR_W'(cur.addr); cpu_wr = cur.wr;
                    cpu_req = 1; busy = 1; granted = 0; saw_wait = 0; tick = 0;
                end
            end
        end
    end

    function automatic op_t mk(int a, bit w, int sh, int sl, bit en, int hold, bit off,
                               int ew, int ec);
        op_t o;
        o.addr = a; o.wr = w; o.sh = sh; o.sl = sl; o.en = en; o.hold = hold;
        o.off = off; o.exp_wait = ew; o.exp_cnt = ec;
        return o;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        started = 1;
        chk("R1 wait", cpu_wait, 0);
        chk("R1 grant", cpu_grant, 0);
        chk("R1 ram_we", ram_we, 0);
        chk("R1 vid_oe", vid_oe, 1);
        chk("R1 count", stall_count, 0);
        rst = 0;
        @(negedge clk);
        chk("R1 post-reset wait", cpu_wait, 0);
        // R2, R3, R9 saturation: long visible stall, write
        q.push_back(mk('h3C10, 1, 10, 0, 1, 0, 0, 1, CNT_MAX));
        // R4: read in horizontal blanking, top window edge
        q.push_back(mk('h3FFF, 0, 85, -1, 1, 0, 0, 0, -1));
        // R5: just past the window, visible
        q.push_back(mk('h4000, 1, 20, 1, 1, 0, 1, -1, -1));
        // R8: last blanking tick before a visible line
        q.push_back(mk('h3C00, 1, 95, 1, 1, 0, 0, 1, CNT_MAX));
        // R10: request held after grant
        q.push_back(mk('h3C20, 1, 88, -1, 1, 3, 0, 0, -1));
        // R4: vertical blanking line, mid-line
        q.push_back(mk('h3C30, 1, 30, 4, 1, 0, 0, 0, -1));
        // R6: arbitration off during visible
        q.push_back(mk('h3C40, 1, 30, 0, 0, 0, 0, 0, -1));
        // R9: short stall, exact length 5
        q.push_back(mk('h3C50, 0, 75, 2, 1, 0, 0, 1, 5));
        while (done < 8 && cycles < 150000) @(negedge clk);
        repeat (4) @(negedge clk);
        if (done < 8) chk("watchdog ops done", done, 8);
        chk("R3 long stall >= 64", (max_run >= 64) ? 1 : 0, 1);
        chk("R10 total grants", grants, 7);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule